// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block is the write-only programming port of a frequency synthesizer. Three wires drive it: an active-low select, a serial clock and a data line. Each frame shifts one 24-bit control word into a shift register, least significant bit first. On the rising serial clock edge that delivers the 24th bit, the block copies the whole word into a bank of holding latches. It does this while the select is still low. The latches drive the synthesizer's configuration fields.

Serial clock edges that come after the 24th bit are ignored until the select returns high. If the select rises before the word is complete, the partial word is discarded and the latches keep their old contents. A one-cycle commit pulse marks every transfer into the latches. An asynchronous active-low reset loads a fixed default configuration.

The control is a three-state machine that runs in the serial clock domain. The select acts as an asynchronous clear of the state and of the bit counter.
- **IDLE**: waiting for the first bit of a frame.
- **SHIFT**: collecting bits 1 to 23.
- **HOLD**: the word has been committed and further bits are discarded.

Transitions:
- **IDLE to SHIFT** on the first sampled bit.
- **SHIFT to HOLD** on the 24th bit. The commit happens on this transition.
- **any state to IDLE** while the select is high, or during reset.

Top module: `synth_cfg_loader`

## Requirements
- R1: While `rst_n` is low and after it is released, the outputs show the default word 0xB8011E: `fb_div`=30, `ref_div`=2, `presc_sel`=0, `aux_div_code`=0, `vco_div_code`=0, `main_oe`=1, `aux_oe`=1, `ref_sel`=0. `commit_pulse` is 0.
- R2: While `cs_n` is low, `sdi` is sampled on each rising `sclk` edge. The k-th sample after the falling edge of `cs_n` (k = 0..23) becomes bit k of the word.
- R3: Fields of the committed word:
  - `fb_div` = bits 6:0
  - `ref_div` = bits 13:7
  - `presc_sel` = bit 14
  - `aux_div_code` = bits 16:15
  - `vco_div_code` = bits 18:17
  - `main_oe` = bit 19
  - `aux_oe` = bit 20
  - `ref_sel` = bit 22
  - Bits 21 and 23 are reserved and drive no output.
- R4: The outputs take the new word on the rising edge that samples the 24th bit, while `cs_n` is still low. `commit_pulse` is high for exactly the one `sclk` cycle that follows that edge.
- R5: Rising `sclk` edges after the 24th in the same frame leave the outputs unchanged and produce no further commit pulse.
- R6: If `cs_n` rises after 1 to 23 bits, the outputs are unchanged and no commit pulse occurs.
- R7: After an aborted frame, the next frame starts again at bit 0 and commits correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select; high clears the frame |
| sdi | input | 1 | Serial data, LSB first |
| fb_div | output | 7 | Feedback divider value |
| ref_div | output | 7 | Reference divider value |
| presc_sel | output | 1 | Prescaler select (0 = divide by 1, 1 = divide by 8) |
| aux_div_code | output | 2 | Divide code of the auxiliary clock output |
| vco_div_code | output | 2 | Divide code of the VCO output |
| main_oe | output | 1 | Main clock output enable (0 = tri-state) |
| aux_oe | output | 1 | Auxiliary clock output enable (0 = tri-state) |
| ref_sel | output | 1 | Reference clock select (1 = reference passed through) |
| commit_pulse | output | 1 | One-cycle pulse after each transfer into the latches |

## Verification
The hardest case to reach is the boundary around the 24th edge. Two things must be shown there:
- The commit happens while the select is still low, and not when it rises.
- An abort one edge before that point changes nothing.

The bench drives frames of every length from 1 to 23 bits and checks after each that the outputs are unchanged. It also drives frames that run well past 24 bits with different data in the surplus bits. It then watches the edge of the 24th bit directly: the outputs must still hold the old word at the sample taken just before that edge, and must hold the new word, with the pulse high, at the sample taken just after it.

// File: rtl/scl_pkg.sv
`timescale 1ns/1ps
package scl_pkg;
    localparam int unsigned CFG_W    = 24;
    localparam int unsigned DIV_W    = 7;
    localparam int unsigned CODE_W   = 2;
    localparam int unsigned FB_LSB   = 0;
    localparam int unsigned REF_LSB  = FB_LSB + DIV_W;
    localparam int unsigned PRE_BIT  = REF_LSB + DIV_W;
    localparam int unsigned AUX_LSB  = PRE_BIT + 1;
    localparam int unsigned VCO_LSB  = AUX_LSB + CODE_W;
    localparam int unsigned MOE_BIT  = VCO_LSB + CODE_W;
    localparam int unsigned AOE_BIT  = MOE_BIT + 1;
    localparam int unsigned RSEL_BIT = AOE_BIT + 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic              ref_sel;
        logic              aux_oe;
        logic              main_oe;
        logic [CODE_W-1:0] vco_code;
        logic [CODE_W-1:0] aux_code;
        logic              presc;
        logic [DIV_W-1:0]  ref_div;
        logic [DIV_W-1:0]  fb_div;
    } synth_cfg_t;

    function automatic synth_cfg_t decode_word(input logic [CFG_W-1:0] w);
        synth_cfg_t c;
        c.fb_div   = w[FB_LSB  +: DIV_W];
        c.ref_div  = w[REF_LSB +: DIV_W];
        c.presc    = w[PRE_BIT];
        c.aux_code = w[AUX_LSB +: CODE_W];
        c.vco_code = w[VCO_LSB +: CODE_W];
        c.main_oe  = w[MOE_BIT];
        c.aux_oe   = w[AOE_BIT];
        c.ref_sel  = w[RSEL_BIT];
        return c;
    endfunction
endpackage

// File: rtl/scl_frame_ctrl.sv
`timescale 1ns/1ps
module scl_frame_ctrl
    import scl_pkg::*;
#(
    parameter int unsigned WORD_W = CFG_W
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic cs_n,
    output logic shift_en,
    output logic take
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    ld_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // State register: the select acts as an asynchronous clear
    always_ff @(posedge sclk or negedge rst_n or posedge cs_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (cs_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_nx   = cnt + CNT_W'(1);
                state_nx = (cnt == LAST) ? ST_HOLD : ST_SHIFT;
            end
            ST_SHIFT: begin
                cnt_nx = cnt + CNT_W'(1);
                if (cnt == LAST) begin
                    state_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                cnt_nx   = cnt;
                state_nx = ST_HOLD;
            end
            default: begin
                cnt_nx   = '0;
                state_nx = ST_IDLE;
            end
        endcase
    end

    // Output logic
    always_comb begin
        shift_en = 1'b0;
        take     = 1'b0;
        unique case (state)
            ST_IDLE, ST_SHIFT: begin
                shift_en = 1'b1;
                take     = (cnt == LAST);
            end
            ST_HOLD: begin
                shift_en = 1'b0;
                take     = 1'b0;
            end
            default: begin
                shift_en = 1'b0;
                take     = 1'b0;
            end
        endcase
    end

    assert_cnt_bound_R5: assert property (@(posedge sclk) disable iff (!rst_n)
        cnt <= FULL);
    assert_hold_full_R5: assert property (@(posedge sclk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (cnt == FULL));
    assert_one_take_R5: assert property (@(posedge sclk) disable iff (!rst_n)
        take |=> !take);
    assert_idle_empty_R7: assert property (@(posedge sclk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cnt == '0));
endmodule

// File: rtl/scl_shift_reg.sv
`timescale 1ns/1ps
module scl_shift_reg
    import scl_pkg::*;
#(
    parameter int unsigned WORD_W = CFG_W
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              sdi,
    output logic [WORD_W-1:0] next_word
);
    logic [WORD_W-1:0] sh_q;

    // First bit enters at the top and walks down to bit 0
    assign next_word = {sdi, sh_q[WORD_W-1:1]};

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (shift_en) begin
            sh_q <= next_word;
        end
    end
endmodule

// File: rtl/scl_cfg_hold.sv
`timescale 1ns/1ps
module scl_cfg_hold
    import scl_pkg::*;
#(
    parameter logic [CFG_W-1:0] DEFAULT_WORD = 24'hB8011E
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [CFG_W-1:0] next_word,
    output synth_cfg_t       cfg,
    output logic             commit_pulse
);
    logic [CFG_W-1:0] word_q;

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            word_q       <= DEFAULT_WORD;
            commit_pulse <= 1'b0;
        end else begin
            commit_pulse <= take;
            if (take) begin
                word_q <= next_word;
            end
        end
    end

    assign cfg = decode_word(word_q);

    assert_cfg_stable_R6: assert property (@(posedge sclk) disable iff (!rst_n)
        !take |=> $stable(word_q));
    assert_commit_copy_R4: assert property (@(posedge sclk) disable iff (!rst_n)
        take |=> (word_q == $past(next_word)));
    assert_pulse_single_R4: assert property (@(posedge sclk) disable iff (!rst_n)
        commit_pulse |=> !commit_pulse);
endmodule

// File: rtl/synth_cfg_loader.sv
`timescale 1ns/1ps
module synth_cfg_loader
    import scl_pkg::*;
#(
    parameter logic [CFG_W-1:0] DEFAULT_WORD = 24'hB8011E
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sdi,
    output logic [DIV_W-1:0]  fb_div,
    output logic [DIV_W-1:0]  ref_div,
    output logic              presc_sel,
    output logic [CODE_W-1:0] aux_div_code,
    output logic [CODE_W-1:0] vco_div_code,
    output logic              main_oe,
    output logic              aux_oe,
    output logic              ref_sel,
    output logic              commit_pulse
);
    logic             shift_en;
    logic             take;
    logic [CFG_W-1:0] next_word;
    synth_cfg_t       cfg;

    scl_frame_ctrl #(.WORD_W(CFG_W)) u_ctrl (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .shift_en (shift_en),
        .take     (take)
    );

    scl_shift_reg #(.WORD_W(CFG_W)) u_shift (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .sdi       (sdi),
        .next_word (next_word)
    );

    scl_cfg_hold #(.DEFAULT_WORD(DEFAULT_WORD)) u_hold (
        .sclk         (sclk),
        .rst_n        (rst_n),
        .take         (take),
        .next_word    (next_word),
        .cfg          (cfg),
        .commit_pulse (commit_pulse)
    );

    assign fb_div       = cfg.fb_div;
    assign ref_div      = cfg.ref_div;
    assign presc_sel    = cfg.presc;
    assign aux_div_code = cfg.aux_code;
    assign vco_div_code = cfg.vco_code;
    assign main_oe      = cfg.main_oe;
    assign aux_oe       = cfg.aux_oe;
    assign ref_sel      = cfg.ref_sel;
endmodule

// File: tb/synth_cfg_loader_test.sv
`timescale 1ns/1ps
module synth_cfg_loader_test;
    logic sclk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic [6:0] fb_div, ref_div;
    logic presc_sel, main_oe, aux_oe, ref_sel, commit_pulse;
    logic [1:0] aux_div_code, vco_div_code;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 0;

    always #4 sclk = ~sclk;

    synth_cfg_loader uut (
        .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
        .fb_div(fb_div), .ref_div(ref_div), .presc_sel(presc_sel),
        .aux_div_code(aux_div_code), .vco_div_code(vco_div_code),
        .main_oe(main_oe), .aux_oe(aux_oe), .ref_sel(ref_sel),
        .commit_pulse(commit_pulse)
    );

    always @(negedge sclk) if (rst_n && commit_pulse) pulses++;

    function automatic logic [21:0] outs();
        return {ref_sel, aux_oe, main_oe, vco_div_code, aux_div_code,
                presc_sel, ref_div, fb_div};
    endfunction

    // Field decode per R3
    function automatic logic [21:0] fields_of(input logic [23:0] w);
        return {w[22], w[20], w[19], w[18:17], w[16:15], w[14], w[13:7], w[6:0]};
    endfunction

    function automatic logic [23:0] make_word(input int k);
        logic [6:0] fb, rf;
        fb = 7'(k);
        rf = 7'((k * 37 + 5) % 128);
        return {1'b1, 1'(k >> 2), 1'b1, 1'(k >> 5), 1'(k >> 4),
                2'((k >> 2) % 4), 2'(k % 4), 1'(k ^ (k >> 3)), rf, fb};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [47:0] bits, input int n);
        @(negedge sclk);
        cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            sdi = bits[i];
            @(negedge sclk);
        end
        cs_n = 1'b1;
        @(negedge sclk);
    endtask

    logic [21:0] exp_cfg;
    int p0;

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        exp_cfg = fields_of(24'hB8011E);
        repeat (3) @(negedge sclk);
        chk(outs() == exp_cfg, "R1 default in reset", 32'(outs()), 32'(exp_cfg));
        rst_n = 1'b1;
        @(negedge sclk);
        chk(outs() == exp_cfg && !commit_pulse, "R1 default after reset",
            32'({commit_pulse, outs()}), 32'(exp_cfg));

        // R2/R3 sweep over 128 words
        for (int k = 0; k < 128; k++) begin
            p0 = pulses;
            send_bits({24'h0, make_word(k)}, 24);
            exp_cfg = fields_of(make_word(k));
            chk(outs() == exp_cfg, "R2 R3 field sweep", 32'(outs()), 32'(exp_cfg));
            chk(pulses == p0 + 1, "R4 one pulse per frame", pulses, p0 + 1);
        end

        // R6 aborts of every short length
        for (int n = 1; n < 24; n++) begin
            p0 = pulses;
            send_bits({24'h0, ~make_word(n + 40)}, n);
            chk(outs() == exp_cfg, "R6 abort keeps config", 32'(outs()), 32'(exp_cfg));
            chk(pulses == p0, "R6 abort no pulse", pulses, p0);
        end

        // R7 frame after an abort starts at bit 0
        send_bits({24'h0, 24'hFFFFFF}, 13);
        send_bits({24'h0, make_word(77)}, 24);
        exp_cfg = fields_of(make_word(77));
        chk(outs() == exp_cfg, "R7 restart after abort", 32'(outs()), 32'(exp_cfg));

        // R5 surplus bits ignored
        for (int x = 1; x <= 24; x += 7) begin
            p0 = pulses;
            send_bits({~make_word(x), make_word(x + 90)}, 24 + x);
            exp_cfg = fields_of(make_word(x + 90));
            chk(outs() == exp_cfg, "R5 surplus bits ignored", 32'(outs()), 32'(exp_cfg));
            chk(pulses == p0 + 1, "R5 no extra pulse", pulses, p0 + 1);
        end

        // R4 commit timing while select stays low
        begin
            logic [23:0] w;
            logic [21:0] old_cfg;
            w = make_word(55);
            old_cfg = outs();
            @(negedge sclk);
            cs_n = 1'b0;
            for (int i = 0; i < 24; i++) begin
                sdi = w[i];
                @(negedge sclk);
                if (i == 22)
                    chk(outs() == old_cfg && !commit_pulse, "R4 no commit at bit 23",
                        32'(outs()), 32'(old_cfg));
            end
            chk(outs() == fields_of(w) && commit_pulse, "R4 commit at 24th edge",
                32'({commit_pulse, outs()}), 32'({1'b1, fields_of(w)}));
            sdi = ~sdi;
            @(negedge sclk);
            chk(!commit_pulse && outs() == fields_of(w), "R4 R5 pulse one cycle",
                32'({commit_pulse, outs()}), 32'(fields_of(w)));
            cs_n = 1'b1;
            @(negedge sclk);
        end

        // R1 asynchronous reset mid-frame
        @(negedge sclk);
        cs_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            sdi = 1'(i);
            @(negedge sclk);
        end
        #2 rst_n = 1'b0;
        #1;
        exp_cfg = fields_of(24'hB8011E);
        chk(outs() == exp_cfg && !commit_pulse, "R1 reset mid-frame",
            32'(outs()), 32'(exp_cfg));
        cs_n = 1'b1;
        @(negedge sclk);
        rst_n = 1'b1;
        send_bits({24'h0, make_word(3)}, 24);
        exp_cfg = fields_of(make_word(3));
        chk(outs() == exp_cfg, "R7 frame after reset", 32'(outs()), 32'(exp_cfg));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule